// File: doc/BRIEF.md
# Transfer-Trip Receive Validator

This block decides whether a remote transfer-trip command, received over up to three differential-protection communication channels, can be passed to the local trip logic. Each channel supplies a trip flag and a strobe marking a valid packet. The block keeps one trip status bit per channel, considers only the channels the active mask currently selects, and ORs their status into one qualified received-trip condition.

The qualified condition can raise the validated trip output in two ways. If the local disturbance detector confirms a change in local currents, the output rises at once. If there is no such confirmation, the condition has to hold without a break for a pickup delay of three quarters of a power-system cycle. In addition, some active channel must have received at least three consecutive packets carrying the trip bit. This guards against packets with bit errors that the error check missed. The pickup delay is counted in sample strobes, and there is no dropout delay. A run-time enable input and a stub-bus mode input can block the output at any time.

Top module: `xfer_trip_validator`

## Requirements
- R1: When a packet is valid on an active channel, the channel status bit `chTripRx[i]` takes that packet's trip bit at the next clock edge. Otherwise the bit keeps its value. While a channel is inactive, its status bit is cleared at each clock edge, and packets arriving on it are ignored.
- R2: The qualified received-trip condition is the OR, over all channels, of `chTripRx[i] & chActive[i]`. The active mask takes effect in the same cycle it changes.
- R3: `tripValid` is 0 in every cycle in which `tripEnable` is 0 or `stubMode` is 1.
- R4: When `distDetect` is 1, and the block is enabled and the qualified condition holds, `tripValid` is 1 in the same cycle, with no delay.
- R5: When `distDetect` is 0, `tripValid` needs a pickup timer to have counted `round(0.75 * SAMPLES_PER_CYCLE)` `sampleTick` strobes. The timer counts only at clock edges where the qualified condition holds and the block is enabled. It returns to zero in any cycle where either of these is false.
- R6: When `distDetect` is 0, `tripValid` also needs some active channel to have a consecutive trip-packet count of at least `CONFIRM_PKTS`.
- R7: A channel's consecutive count goes up by one on each valid trip packet and stops at `CONFIRM_PKTS`. It clears on a valid packet whose trip bit is 0, and it also clears while the channel is inactive.
- R8: The output has no dropout delay. `tripValid` falls in the same cycle the qualified condition or the enable conditions go away.
- R9: A synchronous reset clears every status bit, count and timer, so `tripValid` is 0 in the cycle after a reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleTick | input | 1 | One-cycle strobe for each sample of the cycle time base |
| pktValid | input | NUM_CH | Strobe for each channel marking a valid received packet |
| pktTrip | input | NUM_CH | Trip bit of each channel's packet, sampled with pktValid |
| chActive | input | NUM_CH | Mask selecting the active channels |
| tripEnable | input | 1 | Run-time enable for the validation |
| stubMode | input | 1 | Stub-bus mode; blocks the output when high |
| distDetect | input | 1 | Local disturbance-detector confirmation |
| chTripRx | output | NUM_CH | Received-trip status bit for each channel |
| tripValid | output | 1 | Validated transfer-trip request to the trip logic |

## Verification
The bench builds the block with three channels, a confirmation depth of three packets and `SAMPLES_PER_CYCLE` set to 6. With this value the pickup threshold is 4.5 rounded up to 5, so the rounding is exercised. The pickup window is also short enough that random traffic, with sample strobes on about half the cycles, often reaches both the delayed path and the count saturation. Directed sequences cover the cases random traffic rarely produces: a trip stopped at two packets, a channel that drops out partway through a confirmation, blocking by enable and by stub mode, and a reset in the middle of a trip.

// File: rtl/xtv_pkg.sv
package xtv_pkg;

  // Strobes sent from the control path to the datapath.
  typedef struct packed {
    logic tmrClear;  // return the pickup timer to zero
    logic tmrStep;   // advance the pickup timer by one sample
  } xtv_ctrl_t;

  // Pickup threshold in samples: 0.75 * spc, rounded half up.
  function automatic int unsigned pickupSamples(input int unsigned spc);
    return (3 * spc + 2) / 4;
  endfunction

endpackage

// File: rtl/xtv_datapath.sv
module xtv_datapath
  import xtv_pkg::*;
#(
  parameter int unsigned NUM_CH            = 3,
  parameter int unsigned SAMPLES_PER_CYCLE = 16,
  parameter int unsigned CONFIRM_PKTS      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pktValid,
  input  logic [NUM_CH-1:0] pktTrip,
  input  logic [NUM_CH-1:0] chActive,
  input  xtv_ctrl_t         ctrl,
  output logic [NUM_CH-1:0] rxFlag,
  output logic [NUM_CH-1:0] cntOk,
  output logic              tmrDone
);

  localparam int unsigned THRESH = pickupSamples(SAMPLES_PER_CYCLE);
  localparam int unsigned TW     = $clog2(THRESH + 1);
  localparam int unsigned CW     = $clog2(CONFIRM_PKTS + 1);

  // One status bit and one consecutive-packet counter for each channel.
  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [CW-1:0] pktRun;

    always_ff @(posedge clk) begin
      if (rst || !chActive[g]) begin
        rxFlag[g] <= 1'b0;
        pktRun    <= '0;
      end else if (pktValid[g]) begin
        rxFlag[g] <= pktTrip[g];
        if (!pktTrip[g])
          pktRun <= '0;
        else if (pktRun != CW'(CONFIRM_PKTS))
          pktRun <= pktRun + 1'b1;
      end
    end

    assign cntOk[g] = (pktRun >= CW'(CONFIRM_PKTS));
  end

  // Pickup timer; it counts sample strobes and stops at the threshold.
  logic [TW-1:0] tmrCount;

  always_ff @(posedge clk) begin
    if (rst || ctrl.tmrClear)
      tmrCount <= '0;
    else if (ctrl.tmrStep && (tmrCount != TW'(THRESH)))
      tmrCount <= tmrCount + 1'b1;
  end

  assign tmrDone = (tmrCount == TW'(THRESH));

endmodule

// File: rtl/xtv_control.sv
module xtv_control
  import xtv_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input  logic [NUM_CH-1:0] rxFlag,
  input  logic [NUM_CH-1:0] cntOk,
  input  logic [NUM_CH-1:0] chActive,
  input  logic              tmrDone,
  input  logic              tripEnable,
  input  logic              stubMode,
  input  logic              distDetect,
  input  logic              sampleTick,
  output xtv_ctrl_t         ctrl,
  output logic              tripValid
);

  logic qualified;
  logic allowed;
  logic armed;
  logic confirmed;

  always_comb begin
    qualified = |(rxFlag & chActive);
    allowed   = tripEnable && !stubMode;
    armed     = qualified && allowed;
    confirmed = |(cntOk & chActive);

    ctrl.tmrClear = !armed;
    ctrl.tmrStep  = armed && sampleTick;

    tripValid = armed && (distDetect || (tmrDone && confirmed));
  end

endmodule

// File: rtl/xfer_trip_validator.sv
module xfer_trip_validator
  import xtv_pkg::*;
#(
  parameter int unsigned NUM_CH            = 3,
  parameter int unsigned SAMPLES_PER_CYCLE = 16,
  parameter int unsigned CONFIRM_PKTS      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleTick,
  input  logic [NUM_CH-1:0] pktValid,
  input  logic [NUM_CH-1:0] pktTrip,
  input  logic [NUM_CH-1:0] chActive,
  input  logic              tripEnable,
  input  logic              stubMode,
  input  logic              distDetect,
  output logic [NUM_CH-1:0] chTripRx,
  output logic              tripValid
);

  xtv_ctrl_t         ctrl;
  logic [NUM_CH-1:0] rxFlag;
  logic [NUM_CH-1:0] cntOk;
  logic              tmrDone;

  xtv_datapath #(
    .NUM_CH(NUM_CH),
    .SAMPLES_PER_CYCLE(SAMPLES_PER_CYCLE),
    .CONFIRM_PKTS(CONFIRM_PKTS)
  ) uDatapath (
    .clk(clk),
    .rst(rst),
    .pktValid(pktValid),
    .pktTrip(pktTrip),
    .chActive(chActive),
    .ctrl(ctrl),
    .rxFlag(rxFlag),
    .cntOk(cntOk),
    .tmrDone(tmrDone)
  );

  xtv_control #(
    .NUM_CH(NUM_CH)
  ) uControl (
    .rxFlag(rxFlag),
    .cntOk(cntOk),
    .chActive(chActive),
    .tmrDone(tmrDone),
    .tripEnable(tripEnable),
    .stubMode(stubMode),
    .distDetect(distDetect),
    .sampleTick(sampleTick),
    .ctrl(ctrl),
    .tripValid(tripValid)
  );

  assign chTripRx = rxFlag;

endmodule

// File: rtl/xtv_checker.sv
module xtv_checker
  import xtv_pkg::*;
#(
  parameter int unsigned NUM_CH            = 3,
  parameter int unsigned SAMPLES_PER_CYCLE = 16,
  parameter int unsigned CONFIRM_PKTS      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sampleTick,
  input logic [NUM_CH-1:0] pktValid,
  input logic [NUM_CH-1:0] pktTrip,
  input logic [NUM_CH-1:0] chActive,
  input logic              tripEnable,
  input logic              stubMode,
  input logic              distDetect,
  input logic [NUM_CH-1:0] chTripRx,
  input logic              tripValid
);

  localparam int unsigned THRESH = pickupSamples(SAMPLES_PER_CYCLE);

  logic qualView;
  logic okView;
  logic [NUM_CH-1:0] seenOk;
  int unsigned watch;

  assign qualView = |(chTripRx & chActive) && tripEnable && !stubMode;

  // Sample-strobe count taken from the ports, for the pickup window.
  always_ff @(posedge clk) begin
    if (rst || !qualView)
      watch <= 0;
    else if (sampleTick && watch < THRESH)
      watch <= watch + 1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gSeen
    int unsigned seen;
    always_ff @(posedge clk) begin
      if (rst || !chActive[g])
        seen <= 0;
      else if (pktValid[g])
        seen <= pktTrip[g] ? ((seen < CONFIRM_PKTS) ? seen + 1 : seen) : 0;
    end
    assign seenOk[g] = (seen >= CONFIRM_PKTS);

    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
      (pktValid[g] && chActive[g]) |=> (chTripRx[g] == $past(pktTrip[g])));

    assert_inactive_clear_R1: assert property (@(posedge clk) disable iff (rst)
      !chActive[g] |=> !chTripRx[g]);
  end

  assign okView = |(seenOk & chActive);

  assert_blocked_R3: assert property (@(posedge clk) disable iff (rst)
    (!tripEnable || stubMode) |-> !tripValid);

  assert_instant_R4: assert property (@(posedge clk) disable iff (rst)
    (qualView && distDetect) |-> tripValid);

  assert_delay_R5: assert property (@(posedge clk) disable iff (rst)
    (tripValid && !distDetect) |-> (watch == THRESH));

  assert_confirm_R6: assert property (@(posedge clk) disable iff (rst)
    (tripValid && !distDetect) |-> okView);

  assert_dropout_R8: assert property (@(posedge clk) disable iff (rst)
    !(|(chTripRx & chActive)) |-> !tripValid);

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> !tripValid);

endmodule

bind xfer_trip_validator xtv_checker #(
  .NUM_CH(NUM_CH),
  .SAMPLES_PER_CYCLE(SAMPLES_PER_CYCLE),
  .CONFIRM_PKTS(CONFIRM_PKTS)
) uChecker (.*);

// File: tb/xfer_trip_validator_test.sv
`timescale 1ns/1ps
module xfer_trip_validator_test;

  localparam int NCH    = 3;
  localparam int SPC    = 6;
  localparam int CONF   = 3;
  localparam int THRESH = 5;  // 0.75 * 6 = 4.5, rounded up

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleTick = 1'b0;
  logic [NCH-1:0] pktValid = '0;
  logic [NCH-1:0] pktTrip  = '0;
  logic [NCH-1:0] chActive = '0;
  logic tripEnable = 1'b0;
  logic stubMode   = 1'b0;
  logic distDetect = 1'b0;
  logic [NCH-1:0] chTripRx;
  logic tripValid;

  always #2.5 clk = ~clk;

  xfer_trip_validator #(
    .NUM_CH(NCH), .SAMPLES_PER_CYCLE(SPC), .CONFIRM_PKTS(CONF)
  ) uut (
    .clk(clk), .rst(rst), .sampleTick(sampleTick),
    .pktValid(pktValid), .pktTrip(pktTrip), .chActive(chActive),
    .tripEnable(tripEnable), .stubMode(stubMode), .distDetect(distDetect),
    .chTripRx(chTripRx), .tripValid(tripValid)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Reference state, built from the requirements
  logic [NCH-1:0] mRx = '0;
  int mCnt [NCH] = '{default: 0};
  int mTmr = 0;

  function automatic logic expTrip();
    logic qual, allowed, conf;
    qual    = |(mRx & chActive);
    allowed = tripEnable && !stubMode;
    conf    = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (chActive[i] && mCnt[i] >= CONF) conf = 1'b1;
    return qual && allowed && (distDetect || (mTmr >= THRESH && conf));
  endfunction

  task automatic modelEdge();
    logic arm;
    arm = (|(mRx & chActive)) && tripEnable && !stubMode;
    if (rst) begin
      mRx = '0; mTmr = 0;
      for (int i = 0; i < NCH; i++) mCnt[i] = 0;
    end else begin
      if (!arm) mTmr = 0;
      else if (sampleTick && mTmr < THRESH) mTmr++;
      for (int i = 0; i < NCH; i++) begin
        if (!chActive[i]) begin
          mRx[i] = 1'b0; mCnt[i] = 0;
        end else if (pktValid[i]) begin
          mRx[i] = pktTrip[i];
          mCnt[i] = pktTrip[i] ? ((mCnt[i] < CONF) ? mCnt[i] + 1 : mCnt[i]) : 0;
        end
      end
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s tripValid actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: inputs are already set; compare, then take the edge.
  task automatic step(string tag);
    #1;
    check1(tag, tripValid, expTrip());
    checks++;
    if (chTripRx !== mRx) begin
      errors++;
      $display("FAIL R1 chTripRx actual=%b expected=%b at %0t", chTripRx, mRx, $time);
    end
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic idle();
    pktValid = '0; pktTrip = '0; sampleTick = 1'b0; distDetect = 1'b0;
  endtask

  task automatic sendTrip(int ch, logic bitv, logic tick, string tag);
    pktValid = '0; pktTrip = '0;
    pktValid[ch] = 1'b1; pktTrip[ch] = bitv; sampleTick = tick;
    step(tag);
    idle();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R9: reset state
    step("R9"); step("R9");
    rst = 1'b0; chActive = 3'b111; tripEnable = 1'b1;
    step("R9");

    // R1: status follows valid packets only
    sendTrip(0, 1'b1, 1'b0, "R1");
    pktTrip = 3'b010; step("R1");          // trip bit with no valid strobe
    sendTrip(0, 1'b0, 1'b0, "R1");

    // R4: instant path on channel 1 with local confirmation
    sendTrip(1, 1'b1, 1'b0, "R4");
    distDetect = 1'b1; step("R4");
    // R2: masking channel 1 removes the condition in the same cycle
    chActive = 3'b101; step("R2");
    chActive = 3'b111; distDetect = 1'b0; step("R2");

    // R5/R6: delayed path, three packets on channel 2, tick every cycle
    for (int k = 0; k < 3; k++) sendTrip(2, 1'b1, 1'b1, "R6");
    for (int k = 0; k < 6; k++) begin sampleTick = 1'b1; step("R5"); end
    // R8: trip bit cleared on channel 2 drops the output at once
    sendTrip(2, 1'b0, 1'b0, "R8");
    step("R8");

    // R6: only two packets, long wait, no trip
    for (int k = 0; k < 2; k++) sendTrip(0, 1'b1, 1'b1, "R6");
    for (int k = 0; k < 8; k++) begin sampleTick = 1'b1; step("R6"); end

    // R7: channel 0 drops out partway through a confirmation, count restarts
    chActive = 3'b110; step("R7");
    chActive = 3'b111;
    for (int k = 0; k < 2; k++) sendTrip(0, 1'b1, 1'b1, "R7");
    for (int k = 0; k < 8; k++) begin sampleTick = 1'b1; step("R7"); end
    sendTrip(0, 1'b1, 1'b1, "R7");
    for (int k = 0; k < 7; k++) begin sampleTick = 1'b1; step("R7"); end

    // R3: enable low and stub mode both block, even with local confirmation
    distDetect = 1'b1; tripEnable = 1'b0; step("R3");
    tripEnable = 1'b1; stubMode = 1'b1; step("R3");
    stubMode = 1'b0; step("R4");
    distDetect = 1'b0; sampleTick = 1'b1; step("R5");

    // R9: reset in the middle of a trip
    rst = 1'b1; step("R9");
    rst = 1'b0; step("R9");
    idle();

    // Random traffic
    for (int n = 0; n < 6000; n++) begin
      int mode;
      mode = n / 500;
      rst        = ($urandom % 400) == 0;
      sampleTick = $urandom % 2;
      tripEnable = ($urandom % 20) != 0;
      stubMode   = ($urandom % 25) == 0;
      distDetect = ($urandom % 7) == 0;
      for (int i = 0; i < NCH; i++) begin
        chActive[i] = ($urandom % 40) != 0;
        pktValid[i] = ($urandom % 3) == 0;
        pktTrip[i]  = (mode % 2 == 1) ? (($urandom % 12) != 0) : (($urandom % 4) == 0);
      end
      step(distDetect ? "R4" : "R5");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule